// File: doc/BRIEF.md
# Physical Memory Protection Checker

This block guards every memory request a hart issues: instruction fetches, loads and stores. It holds sixteen protection entries. Each entry pairs a configuration byte (read/write/execute permissions, an address-match mode and a lock bit) with an address register that stores a byte address divided by four. Each request carries its access type, byte address, byte length and the current privilege level. The block scans the entries in fixed priority order and answers in the same cycle. The answer is either an allow or a fault, and a fault carries its exception cause code and the faulting byte address.

Software programs the entries through a simple CSR port. The port has a select, a write enable, write data and a combinational read-back. Select values 0 to 15 reach the sixteen address registers. Select values 16 to 19 reach four configuration words, and each word packs four entries' bytes. Three address-match modes are supported. Top-of-range uses the previous entry's address as the lower bound. The naturally aligned four-byte mode covers one word. The naturally aligned power-of-two mode encodes the region size in the trailing ones of the address register.

Top module: `pmp_guard`

## Requirements
- R1: After reset every address register and configuration word reads back as zero, and every request is allowed.
- R2: A write to a configuration word stores each byte ANDed with 0x9F, so bits 5 and 6 of each byte always read back as zero. Address registers store and return all 32 bits unchanged.
- R3: The byte of entry i sits at bits [8*(i%4)+7 : 8*(i%4)] of the configuration word at select 16+i/4. Within the byte: bit 0 = read, bit 1 = write, bit 2 = execute, bits 4:3 = mode (0 off, 1 top-of-range, 2 four-byte, 3 power-of-two), bit 7 = lock.
- R4: A top-of-range entry i matches word addresses w with lower <= w < top. Here top = addr[i]<<2, lower = addr[i-1]<<2 for i > 0, and lower = 0 for entry 0.
- R5: A four-byte entry matches exactly the four bytes starting at addr<<2.
- R6: A power-of-two entry whose address register ends in k ones (k >= 0) below a zero covers 2^(k+3) bytes, aligned to that size and containing addr<<2.
- R7: The access is tested word by word at byte addresses req_addr+4*j, for j below ceil(len/4). The lowest-index entry that matches any of those words decides the result, whatever higher entries would say.
- R8: If the deciding entry matches only some of the words of the access, the access faults.
- R9: A deciding entry allows the access when the permission bit for the access type is set (type 0 load uses read, type 1 store uses write, type 2 fetch uses execute). It also allows the access when the privilege is machine (encoding 3) and the entry's lock bit is clear.
- R10: A deciding entry with its lock bit set enforces its permission bits at machine privilege as well.
- R11: When no entry matches, the access is allowed if every entry's mode is off or the privilege is machine. Otherwise it faults.
- R12: A fault gives cause 1 for a fetch, 5 for a load and 7 for a store, and reports the request's byte address. An allowed response gives cause 0 and fault address 0.
- R13: rsp_valid equals req_valid in the same cycle. With no request, rsp_ok, rsp_cause and rsp_fault_addr are all zero.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low asynchronous reset |
| csr_we | input | 1 | CSR write enable |
| csr_sel | input | 5 | CSR select: 0-15 address registers, 16-19 configuration words |
| csr_wdata | input | 32 | CSR write data |
| csr_rdata | output | 32 | CSR read data for the selected register (combinational) |
| req_valid | input | 1 | Request present |
| req_type | input | 2 | 0 load, 1 store, 2 fetch |
| req_addr | input | 32 | Request byte address |
| req_len | input | 4 | Request length in bytes (1 to 8) |
| req_priv | input | 2 | Privilege level, 3 = machine |
| rsp_valid | output | 1 | Response present (same cycle as request) |
| rsp_ok | output | 1 | Access allowed |
| rsp_cause | output | 4 | Fault cause code, 0 when allowed |
| rsp_fault_addr | output | 32 | Faulting byte address, 0 when allowed |

## Verification
The checker is tried with single-word accesses placed just inside and just outside each region kind. One pair sits on either side of a top-of-range bound, one pair on either side of a power-of-two boundary, and the four-byte entry gets its own pair. Together these separate off-by-one and inclusive-bound errors. Two-word accesses straddle a region edge, or cross from a higher-priority entry into a lower one. These separate the partial-overlap rule from a plain any-word match and show which entry wins. The same address is also tried at user and machine privilege with the lock bit set and clear, and under an all-off table, to separate the permission path, the machine bypass and the no-match default.

// File: rtl/pmp_guard_pkg.sv
package pmp_guard_pkg;

  typedef enum logic [1:0] {
    ACC_LOAD  = 2'd0,
    ACC_STORE = 2'd1,
    ACC_FETCH = 2'd2
  } acc_e;

  typedef enum logic [1:0] {
    AM_OFF   = 2'd0,
    AM_TOR   = 2'd1,
    AM_NA4   = 2'd2,
    AM_NAPOT = 2'd3
  } amode_e;

  // R3: field positions inside one entry byte
  typedef struct packed {
    logic       lock;
    logic [1:0] rsvd;
    amode_e     mode;
    logic       x;
    logic       w;
    logic       r;
  } ent_cfg_t;

  localparam logic [1:0] PRIV_MACHINE = 2'd3;
  localparam logic [7:0] CFG_KEEP     = 8'h9F;   // R2

  localparam logic [3:0] CAUSE_FETCH = 4'd1;     // R12
  localparam logic [3:0] CAUSE_LOAD  = 4'd5;
  localparam logic [3:0] CAUSE_STORE = 4'd7;

endpackage

// File: rtl/pmp_csr_file.sv
module pmp_csr_file
  import pmp_guard_pkg::*;
#(
  parameter int XLEN  = 32,
  parameter int N_ENT = 16,
  parameter int SEL_W = 5
) (
  input  logic             clk,
  input  logic             rst_n,
  input  logic             we,
  input  logic [SEL_W-1:0] sel,
  input  logic [XLEN-1:0]  wdata,
  output logic [XLEN-1:0]  rdata,
  output ent_cfg_t         cfg_o  [N_ENT],
  output logic [XLEN-1:0]  addr_o [N_ENT]
);
  localparam int CPW = XLEN / 8;   // entry bytes per configuration word

  logic [7:0]      cfg_q  [N_ENT];
  logic [XLEN-1:0] addr_q [N_ENT];

  for (genvar e = 0; e < N_ENT; e++) begin : g_ent
    localparam logic [SEL_W-1:0] ASEL = SEL_W'(e);
    localparam logic [SEL_W-1:0] CSEL = SEL_W'(N_ENT + e / CPW);
    localparam int               BOFS = 8 * (e % CPW);

    always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n) begin
        addr_q[e] <= '0;
        cfg_q[e]  <= '0;
      end else if (we) begin
        if (sel == ASEL) addr_q[e] <= wdata;                        // R2
        if (sel == CSEL) cfg_q[e]  <= wdata[BOFS +: 8] & CFG_KEEP; // R2 R3
      end
    end

    assign cfg_o[e]  = ent_cfg_t'(cfg_q[e]);
    assign addr_o[e] = addr_q[e];
  end

  always_comb begin
    rdata = '0;
    for (int e = 0; e < N_ENT; e++) begin
      if (sel == SEL_W'(e)) rdata = addr_q[e];
      if (sel == SEL_W'(N_ENT + e / CPW)) rdata[8 * (e % CPW) +: 8] = cfg_q[e];
    end
  end

endmodule

// File: rtl/pmp_region.sv
module pmp_region
  import pmp_guard_pkg::*;
#(
  parameter int XLEN      = 32,
  parameter int LEN_W     = 4,
  parameter int MAX_WORDS = 2
) (
  input  ent_cfg_t         cfg_i,
  input  logic [XLEN-1:0]  addr_i,
  input  logic [XLEN-1:0]  prev_addr_i,
  input  logic [XLEN-1:0]  req_addr,
  input  logic [LEN_W-1:0] req_len,
  input  acc_e             req_acc,
  input  logic [1:0]       req_priv,
  output logic             enabled_o,
  output logic             any_hit_o,
  output logic             all_hit_o,
  output logic             grant_o
);
  // Mask of the address bits that must agree for a power-of-two or
  // four-byte region: the trailing-ones run (plus one appended bit unless
  // four-byte mode) becomes don't-care, then scaled to bytes.
  function automatic logic [XLEN-1:0] region_mask(input logic [XLEN-1:0] a,
                                                  input logic            na4);
    logic [XLEN-1:0] m;
    logic [XLEN-1:0] run;
    m   = (a << 1) | XLEN'(!na4);
    run = m & ~(m + XLEN'(1));
    return (~run) << 2;
  endfunction

  function automatic logic [LEN_W:0] word_count(input logic [LEN_W-1:0] len);
    return ({1'b0, len} + (LEN_W + 1)'(3)) >> 2;
  endfunction

  logic [XLEN-1:0] top_b, low_b, mask;
  logic [LEN_W:0]  nwords;
  logic            unused_rsvd;

  assign top_b       = addr_i << 2;
  assign low_b       = prev_addr_i << 2;
  assign mask        = region_mask(addr_i, cfg_i.mode == AM_NA4);
  assign nwords      = word_count(req_len);
  assign enabled_o   = cfg_i.mode != AM_OFF;
  assign unused_rsvd = ^cfg_i.rsvd;

  always_comb begin
    logic [XLEN-1:0] wa;
    logic            hit;
    any_hit_o = 1'b0;
    all_hit_o = 1'b1;
    for (int w = 0; w < MAX_WORDS; w++) begin
      wa = req_addr + XLEN'(w * 4);
      unique case (cfg_i.mode)
        AM_TOR:           hit = (wa >= low_b) && (wa < top_b);      // R4
        AM_NA4, AM_NAPOT: hit = ((wa ^ top_b) & mask) == '0;       // R5 R6
        default:          hit = 1'b0;
      endcase
      if (w < int'(nwords)) begin                                  // R7
        any_hit_o = any_hit_o | hit;
        all_hit_o = all_hit_o & hit;
      end
    end
  end

  // R9 R10
  always_comb begin
    grant_o = (req_priv == PRIV_MACHINE) && !cfg_i.lock;
    unique case (req_acc)
      ACC_LOAD:  grant_o = grant_o | cfg_i.r;
      ACC_STORE: grant_o = grant_o | cfg_i.w;
      ACC_FETCH: grant_o = grant_o | cfg_i.x;
      default:   grant_o = grant_o;
    endcase
  end

endmodule

// File: rtl/pmp_resolve.sv
module pmp_resolve
  import pmp_guard_pkg::*;
#(
  parameter int N_ENT = 16,
  parameter int IDX_W = 4
) (
  input  logic [N_ENT-1:0] enabled,
  input  logic [N_ENT-1:0] any_hit,
  input  logic [N_ENT-1:0] all_hit,
  input  logic [N_ENT-1:0] grant,
  input  logic [1:0]       req_priv,
  output logic             win_found,
  output logic [IDX_W-1:0] win_idx,
  output logic             win_partial,
  output logic             any_enabled,
  output logic             allow
);
  // R7: scan from the highest index down so the lowest hit is kept
  always_comb begin
    win_found = 1'b0;
    win_idx   = '0;
    for (int e = N_ENT - 1; e >= 0; e--) begin
      if (any_hit[e]) begin
        win_found = 1'b1;
        win_idx   = IDX_W'(e);
      end
    end
  end

  assign any_enabled = |enabled;
  assign win_partial = win_found && !all_hit[win_idx];              // R8

  always_comb begin
    if (win_found) allow = !win_partial && grant[win_idx];          // R8 R9
    else           allow = !any_enabled || (req_priv == PRIV_MACHINE); // R11
  end

endmodule

// File: rtl/pmp_guard.sv
module pmp_guard
  import pmp_guard_pkg::*;
#(
  parameter int XLEN    = 32,
  parameter int N_ENT   = 16,
  parameter int MAX_LEN = 8,
  parameter int SEL_W   = 5,
  parameter int LEN_W   = 4
) (
  input  logic             clk,
  input  logic             rst_n,
  input  logic             csr_we,
  input  logic [SEL_W-1:0] csr_sel,
  input  logic [XLEN-1:0]  csr_wdata,
  output logic [XLEN-1:0]  csr_rdata,
  input  logic             req_valid,
  input  logic [1:0]       req_type,
  input  logic [XLEN-1:0]  req_addr,
  input  logic [LEN_W-1:0] req_len,
  input  logic [1:0]       req_priv,
  output logic             rsp_valid,
  output logic             rsp_ok,
  output logic [3:0]       rsp_cause,
  output logic [XLEN-1:0]  rsp_fault_addr
);
  localparam int MAX_WORDS = (MAX_LEN + 3) / 4;
  localparam int IDX_W     = $clog2(N_ENT);

  ent_cfg_t        cfg  [N_ENT];
  logic [XLEN-1:0] addr [N_ENT];
  acc_e            acc;

  logic [N_ENT-1:0] ent_enabled, ent_any_hit, ent_all_hit, ent_grant;
  logic             win_found, win_partial, any_enabled, allow;
  logic [IDX_W-1:0] win_idx;

  assign acc = (req_type == 2'd2) ? ACC_FETCH :
               (req_type == 2'd1) ? ACC_STORE : ACC_LOAD;

  pmp_csr_file #(.XLEN(XLEN), .N_ENT(N_ENT), .SEL_W(SEL_W)) u_csr (
    .clk    (clk),
    .rst_n  (rst_n),
    .we     (csr_we),
    .sel    (csr_sel),
    .wdata  (csr_wdata),
    .rdata  (csr_rdata),
    .cfg_o  (cfg),
    .addr_o (addr)
  );

  for (genvar e = 0; e < N_ENT; e++) begin : g_region
    logic [XLEN-1:0] prev;
    if (e == 0) begin : g_first
      assign prev = '0;                                           // R4
    end else begin : g_rest
      assign prev = addr[e-1];
    end

    pmp_region #(.XLEN(XLEN), .LEN_W(LEN_W), .MAX_WORDS(MAX_WORDS)) u_region (
      .cfg_i       (cfg[e]),
      .addr_i      (addr[e]),
      .prev_addr_i (prev),
      .req_addr    (req_addr),
      .req_len     (req_len),
      .req_acc     (acc),
      .req_priv    (req_priv),
      .enabled_o   (ent_enabled[e]),
      .any_hit_o   (ent_any_hit[e]),
      .all_hit_o   (ent_all_hit[e]),
      .grant_o     (ent_grant[e])
    );
  end

  pmp_resolve #(.N_ENT(N_ENT), .IDX_W(IDX_W)) u_resolve (
    .enabled     (ent_enabled),
    .any_hit     (ent_any_hit),
    .all_hit     (ent_all_hit),
    .grant       (ent_grant),
    .req_priv    (req_priv),
    .win_found   (win_found),
    .win_idx     (win_idx),
    .win_partial (win_partial),
    .any_enabled (any_enabled),
    .allow       (allow)
  );

  // R12 R13
  logic fault;
  assign fault          = req_valid && !allow;
  assign rsp_valid      = req_valid;
  assign rsp_ok         = req_valid && allow;
  assign rsp_fault_addr = fault ? req_addr : '0;

  always_comb begin
    rsp_cause = 4'd0;
    if (fault) begin
      unique case (acc)
        ACC_FETCH: rsp_cause = CAUSE_FETCH;
        ACC_STORE: rsp_cause = CAUSE_STORE;
        default:   rsp_cause = CAUSE_LOAD;
      endcase
    end
  end

endmodule

// File: rtl/pmp_guard_chk.sv
module pmp_guard_chk #(
  parameter int XLEN  = 32,
  parameter int N_ENT = 16,
  parameter int SEL_W = 5
) (
  input logic             clk,
  input logic             rst_n,
  input logic [SEL_W-1:0] csr_sel,
  input logic [XLEN-1:0]  csr_rdata,
  input logic             req_valid,
  input logic [1:0]       req_type,
  input logic [1:0]       req_priv,
  input logic [XLEN-1:0]  req_addr,
  input logic             rsp_valid,
  input logic             rsp_ok,
  input logic [3:0]       rsp_cause,
  input logic [XLEN-1:0]  rsp_fault_addr,
  input logic             win_found,
  input logic             win_partial,
  input logic             any_enabled
);
  localparam logic [XLEN-1:0] RSVD_BITS = {(XLEN / 8){8'h60}};

  AST_CFG_RSVD_CLEAR: assert property (@(posedge clk) disable iff (!rst_n)
    (int'(csr_sel) >= N_ENT) |-> ((csr_rdata & RSVD_BITS) == '0)); // R2

  AST_PARTIAL_DENY: assert property (@(posedge clk) disable iff (!rst_n)
    (req_valid && win_found && win_partial) |-> !rsp_ok); // R8

  AST_NOMATCH_MACHINE: assert property (@(posedge clk) disable iff (!rst_n)
    (req_valid && !win_found && req_priv == 2'd3) |-> rsp_ok); // R11

  AST_ALL_OFF_ALLOW: assert property (@(posedge clk) disable iff (!rst_n)
    (req_valid && !any_enabled) |-> rsp_ok); // R11

  AST_CAUSE_CODE: assert property (@(posedge clk) disable iff (!rst_n)
    (rsp_valid && !rsp_ok) |->
      (rsp_cause == (req_type == 2'd2 ? 4'd1 : req_type == 2'd1 ? 4'd7 : 4'd5))); // R12

  AST_FAULT_ADDR: assert property (@(posedge clk) disable iff (!rst_n)
    (rsp_valid && !rsp_ok) |-> (rsp_fault_addr == req_addr)); // R12

  AST_ALLOW_QUIET: assert property (@(posedge clk) disable iff (!rst_n)
    rsp_ok |-> (rsp_cause == 4'd0 && rsp_fault_addr == '0)); // R12

  AST_IDLE_QUIET: assert property (@(posedge clk) disable iff (!rst_n)
    !req_valid |-> (!rsp_valid && !rsp_ok && rsp_cause == 4'd0)); // R13

endmodule

bind pmp_guard pmp_guard_chk #(.XLEN(XLEN), .N_ENT(N_ENT), .SEL_W(SEL_W)) u_chk (
  .clk            (clk),
  .rst_n          (rst_n),
  .csr_sel        (csr_sel),
  .csr_rdata      (csr_rdata),
  .req_valid      (req_valid),
  .req_type       (req_type),
  .req_priv       (req_priv),
  .req_addr       (req_addr),
  .rsp_valid      (rsp_valid),
  .rsp_ok         (rsp_ok),
  .rsp_cause      (rsp_cause),
  .rsp_fault_addr (rsp_fault_addr),
  .win_found      (win_found),
  .win_partial    (win_partial),
  .any_enabled    (any_enabled)
);

// File: tb/test_pmp_guard.sv
`timescale 1ns/1ps
module test_pmp_guard;
  logic        clk = 1'b0;
  logic        rst_n = 1'b0;
  logic        csr_we = 1'b0;
  logic [4:0]  csr_sel = '0;
  logic [31:0] csr_wdata = '0;
  logic [31:0] csr_rdata;
  logic        req_valid = 1'b0;
  logic [1:0]  req_type = '0;
  logic [31:0] req_addr = '0;
  logic [3:0]  req_len = 4'd4;
  logic [1:0]  req_priv = '0;
  logic        rsp_valid, rsp_ok;
  logic [3:0]  rsp_cause;
  logic [31:0] rsp_fault_addr;

  int n_chk = 0;
  int n_err = 0;
  bit done  = 1'b0;

  typedef struct {
    logic        ok;
    logic [3:0]  cause;
    logic [31:0] faddr;
    string       tag;
  } exp_t;
  exp_t sb[$];

  localparam logic [1:0] LD = 2'd0, ST = 2'd1, IF = 2'd2;
  localparam logic [1:0] USR = 2'd0, MCH = 2'd3;

  always #2.5 clk = ~clk;

  pmp_guard i_pmp_guard (
    .clk(clk), .rst_n(rst_n), .csr_we(csr_we), .csr_sel(csr_sel),
    .csr_wdata(csr_wdata), .csr_rdata(csr_rdata), .req_valid(req_valid),
    .req_type(req_type), .req_addr(req_addr), .req_len(req_len),
    .req_priv(req_priv), .rsp_valid(rsp_valid), .rsp_ok(rsp_ok),
    .rsp_cause(rsp_cause), .rsp_fault_addr(rsp_fault_addr)
  );

  function automatic logic [3:0] cause_of(input logic [1:0] ty);
    if (ty == IF) return 4'd1;
    if (ty == ST) return 4'd7;
    return 4'd5;
  endfunction

  // driver: one request per cycle, expected item into the scoreboard
  task automatic access(input logic [1:0] ty, input logic [31:0] a,
                        input logic [3:0] len, input logic [1:0] pv,
                        input bit ok, input string tag);
    exp_t e;
    @(posedge clk); #1;
    req_valid = 1'b1; req_type = ty; req_addr = a; req_len = len; req_priv = pv;
    e.ok = ok; e.cause = ok ? 4'd0 : cause_of(ty); e.faddr = ok ? 32'd0 : a; e.tag = tag;
    sb.push_back(e);
  endtask

  task automatic idle();
    @(posedge clk); #1;
    req_valid = 1'b0;
  endtask

  task automatic csr_wr(input logic [4:0] s, input logic [31:0] d);
    @(posedge clk); #1;
    req_valid = 1'b0; csr_we = 1'b1; csr_sel = s; csr_wdata = d;
    @(posedge clk); #1;
    csr_we = 1'b0;
  endtask

  task automatic csr_chk(input logic [4:0] s, input logic [31:0] exp, input string tag);
    @(posedge clk); #1;
    csr_sel = s;
    @(negedge clk);
    n_chk++;
    if (csr_rdata !== exp) begin
      n_err++;
      $display("FAIL %s: csr sel %0d actual %h expected %h", tag, s, csr_rdata, exp);
    end
  endtask

  // monitor: pop and compare each response
  always @(negedge clk) begin
    if (rst_n && rsp_valid) begin
      n_chk++;
      if (sb.size() == 0) begin
        n_err++;
        $display("FAIL R13: response with no expected item, actual ok=%0b expected none", rsp_ok);
      end else begin
        exp_t e;
        e = sb.pop_front();
        if (rsp_ok !== e.ok || rsp_cause !== e.cause || rsp_fault_addr !== e.faddr) begin
          n_err++;
          $display("FAIL %s: actual ok=%0b cause=%0d addr=%h expected ok=%0b cause=%0d addr=%h",
                   e.tag, rsp_ok, rsp_cause, rsp_fault_addr, e.ok, e.cause, e.faddr);
        end
      end
    end
  end

  initial begin
    #(200_000 * 5);
    if (!done) begin
      n_chk++; n_err++;
      $display("FAIL watchdog: actual hung expected completion");
      $display("Result: errors=%0d of %0d checks", n_err, n_chk);
      $finish;
    end
  end

  initial begin
    repeat (3) @(posedge clk);
    #1 rst_n = 1'b1;

    // R1: reset state
    csr_chk(5'd16, 32'h0, "R1 cfg word reset");
    csr_chk(5'd5,  32'h0, "R1 addr reset");
    access(LD, 32'h0000_0100, 4'd4, USR, 1'b1, "R1 all-off allow");
    access(ST, 32'hFFFF_FFF0, 4'd8, USR, 1'b1, "R11 all-off allow store");
    idle();

    // R2: byte masking and full address storage
    csr_wr(5'd19, 32'hFFFF_FFFF);
    csr_chk(5'd19, 32'h9F9F_9F9F, "R2 cfg mask");
    csr_wr(5'd19, 32'h0);
    csr_wr(5'd7, 32'hDEAD_BEEF);
    csr_chk(5'd7, 32'hDEAD_BEEF, "R2 addr readback");
    csr_wr(5'd7, 32'h0);

    // entry0 four-byte @0x1000 R; entry1 top-of-range to 0x2000 RW;
    // entry2 power-of-two 64B @0x4000 X locked; entry5 four-byte @0x9000 R
    csr_wr(5'd0, 32'h0000_0400);
    csr_wr(5'd1, 32'h0000_0800);
    csr_wr(5'd2, 32'h0000_1007);
    csr_wr(5'd5, 32'h0000_2400);
    csr_wr(5'd16, 32'h009C_0B11);
    csr_wr(5'd17, 32'h0000_1100);
    csr_chk(5'd16, 32'h009C_0B11, "R3 cfg word0 readback");
    csr_chk(5'd17, 32'h0000_1100, "R3 cfg word1 readback");

    access(LD, 32'h0000_1000, 4'd4, USR, 1'b1, "R5 four-byte read");
    access(ST, 32'h0000_1000, 4'd4, USR, 1'b0, "R7 entry0 wins over entry1");
    access(ST, 32'h0000_1800, 4'd4, USR, 1'b1, "R4 inside top-of-range");
    access(ST, 32'h0000_1FFC, 4'd4, USR, 1'b1, "R4 last word below top");
    access(ST, 32'h0000_2000, 4'd4, USR, 1'b0, "R4 top exclusive");
    access(LD, 32'h0000_0FFC, 4'd4, USR, 1'b0, "R4 below lower bound");
    access(IF, 32'h0000_4020, 4'd4, USR, 1'b1, "R6 power-of-two fetch");
    access(IF, 32'h0000_403C, 4'd4, USR, 1'b1, "R6 power-of-two last word");
    access(IF, 32'h0000_4040, 4'd4, USR, 1'b0, "R6 past region end");
    access(LD, 32'h0000_4000, 4'd4, USR, 1'b0, "R9 no read permission");
    access(LD, 32'h0000_4000, 4'd4, MCH, 1'b0, "R10 locked in machine");
    access(ST, 32'h0000_1000, 4'd4, MCH, 1'b1, "R9 machine bypass unlocked");
    access(LD, 32'h0000_8000, 4'd4, MCH, 1'b1, "R11 no match machine");
    access(LD, 32'h0000_8000, 4'd4, USR, 1'b0, "R11 no match user");
    access(LD, 32'h0000_1FFC, 4'd8, USR, 1'b0, "R8 straddles top");
    access(LD, 32'h0000_1800, 4'd8, USR, 1'b1, "R8 both words inside");
    access(LD, 32'h0000_0FFC, 4'd8, USR, 1'b0, "R8 partial on entry0");
    access(LD, 32'h0000_9000, 4'd4, USR, 1'b1, "R3 entry5 byte position");
    access(LD, 32'h0000_9004, 4'd4, USR, 1'b0, "R5 next word outside");
    idle();

    // R13: no request, quiet outputs
    @(negedge clk);
    n_chk++;
    if (rsp_valid !== 1'b0 || rsp_ok !== 1'b0 || rsp_cause !== 4'd0 || rsp_fault_addr !== 32'd0) begin
      n_err++;
      $display("FAIL R13: actual valid=%0b ok=%0b cause=%0d expected 0 0 0",
               rsp_valid, rsp_ok, rsp_cause);
    end

    // R4: entry 0 top-of-range starts at zero
    csr_wr(5'd16, 32'h0000_0009);
    csr_wr(5'd17, 32'h0);
    access(LD, 32'h0000_0000, 4'd4, USR, 1'b1, "R4 entry0 lower bound zero");
    access(LD, 32'h0000_0FFC, 4'd4, USR, 1'b1, "R4 entry0 last word");
    access(LD, 32'h0000_1000, 4'd4, USR, 1'b0, "R4 entry0 top");
    access(ST, 32'h0000_0010, 4'd4, USR, 1'b0, "R9 no write permission");
    idle();
    repeat (2) @(posedge clk);

    n_chk++;
    if (sb.size() != 0) begin
      n_err++;
      $display("FAIL R13: actual %0d unanswered items expected 0", sb.size());
    end

    done = 1'b1;
    $display("Result: errors=%0d of %0d checks", n_err, n_chk);
    $finish;
  end
endmodule